// File: doc/BRIEF.md
# Overflow Reset Watchdog Timer

This block is a 32-bit watchdog that counts upward, one step for each tick of a slow timer clock of about 32 kHz. That clock reaches the block as a single-cycle enable, `tick_i`, in the fast system clock domain. If software lets the count pass its all-ones value, the block starts a reset pulse that lasts a fixed number of ticks and sets a sticky interrupt flag. At the end of the pulse the counter restarts from a software-defined reload value.

Software talks to the block through a simple register port that takes one request per cycle. Each request is answered one cycle later with an acknowledge, read data and an error flag. Through this port software can:

- read or overwrite the live count;
- set the reload value;
- kick the watchdog by writing a new value to a trigger register;
- stop or restart the counter with two-word key sequences;
- clear the interrupt.

Accesses may be a full 32-bit word or either 16-bit half. All other byte-enable patterns are refused.

Top module: `ovf_watchdog`

## Requirements
- R1: After reset the count, the reload value and the stored trigger are 0, the counter is running (control bit 0 = 1), and `wdt_rst_o` and `wdt_irq_o` are low. Word map: 0 count, 1 reload, 2 trigger, 3 control/key, 4 interrupt.
- R2: While running and not in a reset pulse, each cycle with `tick_i` high adds 1 to the count. A cycle without a tick leaves the count unchanged.
- R3: A tick that arrives while the count is 0xFFFFFFFF wraps the count to 0 and drives `wdt_rst_o` high on the next clock edge.
- R4: `wdt_rst_o` stays high for exactly PULSE_LEN ticks (default 8), with the count held at 0 during that time. On the tick that ends the pulse, the count loads the reload value.
- R5: An overflow sets `wdt_irq_o`, and interrupt register bit 0 reads the same flag. The flag stays set until software writes a 1 to bit 0 of word 4. Writing a 0 has no effect.
- R6: A write to word 0 sets the count. A write to word 1 sets the reload value. Both words read back what was written.
- R7: A write to word 2 stores the value. If the new value differs from the stored one, the count loads the reload value. If it is equal, the count is left as it was.
- R8: Writing 0x0000AA55 and then 0x000055AA to word 3 stops the counter (control bit 0 = 0). Writing 0x0000BB66 and then 0x000066BB restarts it. Any other value breaks the sequence, and a second key that arrives alone has no effect.
- R9: A byte enable of 4'b1100 or 4'b0011 writes only that 16-bit half. The other half keeps its old value, or 0 for the key and interrupt words.
- R10: Any other byte enable except 4'b1111 is acknowledged with `bus_err_o` = 1 and changes nothing.
- R11: When an overflow and a clearing write to word 4 fall in the same cycle, the interrupt flag ends set.
- R12: When an overflow and a write to word 0 or word 2 fall in the same cycle, the overflow wins: the count goes to 0 and a reset pulse starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable per timer clock period |
| bus_sel_i | input | 1 | Request valid |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Word index |
| bus_be_i | input | 4 | Byte enables |
| bus_wdata_i | input | 32 | Write data, in lane positions |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_ack_o | output | 1 | Response valid, one cycle after request |
| bus_err_o | output | 1 | Access size refused |
| wdt_rst_o | output | 1 | Reset pulse on overflow |
| wdt_irq_o | output | 1 | Sticky overflow interrupt |

## Verification
Two pairs of events can collide in a single clock cycle. The first is an overflow and a software write that clears the interrupt. The second is an overflow and a software write that reloads or kicks the count. The bench provokes each collision by raising `tick_i` in the exact cycle that presents the register write, with the count preset to 0xFFFFFFFF. It then judges the result from what follows. The interrupt must still be set after the clear attempt. After the kick attempt, the count must read 0 and a full reset pulse must run; only then does the count take the reload value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int DW = 32;

  typedef enum logic [2:0] {
    REG_COUNT = 3'd0,
    REG_LOAD  = 3'd1,
    REG_TRIG  = 3'd2,
    REG_CTRL  = 3'd3,
    REG_IRQ   = 3'd4
  } reg_idx_e;

  localparam logic [DW-1:0] KEY_STOP_1  = 32'h0000_AA55;
  localparam logic [DW-1:0] KEY_STOP_2  = 32'h0000_55AA;
  localparam logic [DW-1:0] KEY_START_1 = 32'h0000_BB66;
  localparam logic [DW-1:0] KEY_START_2 = 32'h0000_66BB;

  // legal access sizes: full word or either half word
  function automatic logic size_ok(input logic [3:0] be);
    return (be == 4'b1111) || (be == 4'b0011) || (be == 4'b1100);
  endfunction

  // combine new lanes into an old word per 16-bit half
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [3:0]    be);
    logic [DW-1:0] r;
    r[15:0]  = be[0] ? new_w[15:0]  : old_w[15:0];
    r[31:16] = be[2] ? new_w[31:16] : old_w[31:16];
    return r;
  endfunction

endpackage

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        be_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW-1:0]     cnt_i,
  input  logic [DW-1:0]     load_i,
  input  logic [DW-1:0]     trig_i,
  input  logic              en_i,
  input  logic              irq_i,
  output logic              wr_count_o,
  output logic              wr_load_o,
  output logic              wr_trig_o,
  output logic              wr_ctrl_o,
  output logic              wr_irq_o,
  output logic [DW-1:0]     wval_o,
  output logic [DW-1:0]     rdata_o,
  output logic              ack_o,
  output logic              err_o
);

  localparam int NREG = 5;

  logic          in_map;
  logic [2:0]    idx;
  logic          wr_ok;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] wr_base;

  assign in_map = (addr_i < ADDR_W'(NREG));
  assign idx    = addr_i[2:0];
  assign wr_ok  = sel_i && wr_i && in_map && size_ok(be_i);

  always_comb begin
    rd_mux  = '0;
    wr_base = '0;
    if (in_map) begin
      case (reg_idx_e'(idx))
        REG_COUNT: begin rd_mux = cnt_i;  wr_base = cnt_i;  end
        REG_LOAD:  begin rd_mux = load_i; wr_base = load_i; end
        REG_TRIG:  begin rd_mux = trig_i; wr_base = trig_i; end
        REG_CTRL:  rd_mux = {{(DW-1){1'b0}}, en_i};
        REG_IRQ:   rd_mux = {{(DW-1){1'b0}}, irq_i};
        default:   rd_mux = '0;
      endcase
    end
  end

  assign wval_o     = lane_merge(wr_base, wdata_i, be_i);
  assign wr_count_o = wr_ok && (idx == REG_COUNT);
  assign wr_load_o  = wr_ok && (idx == REG_LOAD);
  assign wr_trig_o  = wr_ok && (idx == REG_TRIG);
  assign wr_ctrl_o  = wr_ok && (idx == REG_CTRL);
  assign wr_irq_o   = wr_ok && (idx == REG_IRQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o   <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ack_o   <= sel_i;
      err_o   <= sel_i && !size_ok(be_i);
      rdata_o <= (sel_i && !wr_i && size_ok(be_i)) ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
  import wdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_ctrl_i,
  input  logic [DW-1:0] wval_i,
  output logic          en_o
);

  typedef enum logic [1:0] {K_IDLE, K_STOP_ARMED, K_START_ARMED} key_st_e;
  key_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= K_IDLE;
      en_o <= 1'b1;
    end else if (wr_ctrl_i) begin
      if (st == K_STOP_ARMED && wval_i == KEY_STOP_2) begin
        en_o <= 1'b0;
        st   <= K_IDLE;
      end else if (st == K_START_ARMED && wval_i == KEY_START_2) begin
        en_o <= 1'b1;
        st   <= K_IDLE;
      end else if (wval_i == KEY_STOP_1) begin
        st <= K_STOP_ARMED;
      end else if (wval_i == KEY_START_1) begin
        st <= K_START_ARMED;
      end else begin
        st <= K_IDLE;
      end
    end
  end

endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          wr_count_i,
  input  logic          wr_load_i,
  input  logic          wr_trig_i,
  input  logic          wr_irq_i,
  input  logic [DW-1:0] wval_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] load_o,
  output logic [DW-1:0] trig_o,
  output logic          irq_o,
  output logic          pulse_o
);

  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [DW-1:0] CNT_MAX = '1;

  logic [PW-1:0] pcnt;
  logic          ovf;

  assign ovf = tick_i && en_i && !pulse_o && (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      load_o  <= '0;
      trig_o  <= '0;
      irq_o   <= 1'b0;
      pulse_o <= 1'b0;
      pcnt    <= '0;
    end else begin
      if (wr_load_i) load_o <= wval_i;
      if (wr_trig_i) trig_o <= wval_i;

      if (pulse_o) begin
        if (tick_i) begin
          pcnt <= pcnt - 1'b1;
          if (pcnt == PW'(1)) begin
            pulse_o <= 1'b0;
            cnt_o   <= load_o;
          end
        end
      end else if (ovf) begin
        cnt_o   <= '0;
        pulse_o <= 1'b1;
        pcnt    <= PW'(PULSE_LEN);
      end else if (wr_count_i) begin
        cnt_o <= wval_i;
      end else if (wr_trig_i && (wval_i != trig_o)) begin
        cnt_o <= load_o;
      end else if (tick_i && en_i) begin
        cnt_o <= cnt_o + 1'b1;
      end

      if (ovf)                        irq_o <= 1'b1;
      else if (wr_irq_i && wval_i[0]) irq_o <= 1'b0;
    end
  end

endmodule

// File: rtl/ovf_watchdog.sv
module ovf_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int PULSE_LEN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [3:0]        bus_be_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              bus_ack_o,
  output logic              bus_err_o,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);

  logic          wr_count, wr_load, wr_trig, wr_ctrl, wr_irq;
  logic [DW-1:0] wval, cnt, load, trig;
  logic          en;

  wdt_regif #(.ADDR_W(ADDR_W)) u_regif (
    .clk(clk), .rst(rst),
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .be_i(bus_be_i), .wdata_i(bus_wdata_i),
    .cnt_i(cnt), .load_i(load), .trig_i(trig), .en_i(en), .irq_i(wdt_irq_o),
    .wr_count_o(wr_count), .wr_load_o(wr_load), .wr_trig_o(wr_trig),
    .wr_ctrl_o(wr_ctrl), .wr_irq_o(wr_irq), .wval_o(wval),
    .rdata_o(bus_rdata_o), .ack_o(bus_ack_o), .err_o(bus_err_o)
  );

  wdt_keyseq u_keys (
    .clk(clk), .rst(rst), .wr_ctrl_i(wr_ctrl), .wval_i(wval), .en_o(en)
  );

  wdt_core #(.PULSE_LEN(PULSE_LEN)) u_core (
    .clk(clk), .rst(rst), .tick_i(tick_i), .en_i(en),
    .wr_count_i(wr_count), .wr_load_i(wr_load), .wr_trig_i(wr_trig),
    .wr_irq_i(wr_irq), .wval_i(wval),
    .cnt_o(cnt), .load_o(load), .trig_o(trig),
    .irq_o(wdt_irq_o), .pulse_o(wdt_rst_o)
  );

endmodule

// File: rtl/ovf_watchdog_chk.sv
module ovf_watchdog_chk
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int PULSE_LEN = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              bus_sel_i,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [3:0]        bus_be_i,
  input logic              wdat0,
  input logic              bus_ack_o,
  input logic              bus_err_o,
  input logic              wdt_rst_o,
  input logic              wdt_irq_o
);

  localparam int PW = $clog2(PULSE_LEN + 2);
  logic [PW-1:0] hi_ticks;

  always_ff @(posedge clk) begin
    if (rst || !wdt_rst_o) hi_ticks <= '0;
    else if (tick_i)       hi_ticks <= hi_ticks + 1'b1;
  end

  // R4: pulse never outlives its tick budget
  a_r4_pulse_bound: assert property (@(posedge clk) disable iff (rst)
    hi_ticks <= PW'(PULSE_LEN));

  // R3: reset output moves only after a tick
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> $past(tick_i));

  a_r4_stable_no_tick: assert property (@(posedge clk) disable iff (rst)
    !$past(tick_i) |-> $stable(wdt_rst_o));

  // R5: interrupt accompanies the reset pulse
  a_r5_irq_with_rst: assert property (@(posedge clk) disable iff (rst)
    $rose(wdt_rst_o) |-> wdt_irq_o);

  // R5: flag only drops after a clearing write
  a_r5_irq_clear_by_write: assert property (@(posedge clk) disable iff (rst)
    $fell(wdt_irq_o) |-> $past(bus_sel_i && bus_wr_i && size_ok(bus_be_i) &&
                               bus_be_i[0] && wdat0 && bus_addr_i == ADDR_W'(4)));

  // R10: error only for refused sizes, ack only for requests
  a_r10_err_illegal: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_o && bus_err_o) |-> $past(bus_sel_i && !size_ok(bus_be_i)));

  a_r10_ack_follows_req: assert property (@(posedge clk) disable iff (rst)
    bus_ack_o |-> $past(bus_sel_i));

endmodule

bind ovf_watchdog ovf_watchdog_chk #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i),
  .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
  .bus_be_i(bus_be_i), .wdat0(bus_wdata_i[0]),
  .bus_ack_o(bus_ack_o), .bus_err_o(bus_err_o),
  .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
);

// File: tb/test_ovf_watchdog.sv
`timescale 1ns/1ps
module test_ovf_watchdog;

  localparam int ADDR_W = 3;
  localparam int PL     = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_i = 1'b0;
  logic              bus_sel_i = 1'b0;
  logic              bus_wr_i = 1'b0;
  logic [ADDR_W-1:0] bus_addr_i = '0;
  logic [3:0]        bus_be_i = '0;
  logic [31:0]       bus_wdata_i = '0;
  logic [31:0]       bus_rdata_o;
  logic              bus_ack_o, bus_err_o, wdt_rst_o, wdt_irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  ovf_watchdog #(.ADDR_W(ADDR_W), .PULSE_LEN(PL)) i_ovf_watchdog (.*);

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input int a, input logic [3:0] be,
                        input logic [31:0] d, input logic with_tick,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel_i = 1'b1; bus_wr_i = wr; bus_addr_i = ADDR_W'(a);
    bus_be_i = be; bus_wdata_i = d; tick_i = with_tick;
    @(negedge clk);
    bus_sel_i = 1'b0; tick_i = 1'b0;
    rd = bus_rdata_o; er = bus_err_o;
  endtask

  task automatic wr32(input int a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    access(1'b1, a, 4'hF, d, 1'b0, rd, er);
  endtask

  task automatic rd32(input int a, output logic [31:0] rd);
    logic er;
    access(1'b0, a, 4'hF, 32'h0, 1'b0, rd, er);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 rst_o", {31'b0, wdt_rst_o}, 0);
    check("R1 irq_o", {31'b0, wdt_irq_o}, 0);
    rd32(0, v); check("R1 count", v, 0);
    rd32(1, v); check("R1 reload", v, 0);
    rd32(3, v); check("R1 ctrl", v, 1);
  endtask

  task automatic t_count;
    logic [31:0] v;
    wr32(0, 32'd100);
    rd32(0, v); check("R6 count write", v, 100);
    ticks(5);
    rd32(0, v); check("R2 five ticks", v, 105);
    repeat (10) @(negedge clk);
    rd32(0, v); check("R2 no tick hold", v, 105);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr32(1, 32'h1000);
    rd32(1, v); check("R6 reload rd", v, 32'h1000);
    wr32(0, 32'hFFFF_FFFF);
    ticks(1);
    check("R3 rst high", {31'b0, wdt_rst_o}, 1);
    check("R5 irq set", {31'b0, wdt_irq_o}, 1);
    rd32(0, v); check("R3 wrap to 0", v, 0);
    ticks(PL - 1);
    check("R4 still high", {31'b0, wdt_rst_o}, 1);
    rd32(0, v); check("R4 held 0", v, 0);
    ticks(1);
    check("R4 pulse end", {31'b0, wdt_rst_o}, 0);
    rd32(0, v); check("R4 reload", v, 32'h1000);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr32(4, 32'h0);
    rd32(4, v); check("R5 write 0 no clear", v, 1);
    wr32(4, 32'h1);
    rd32(4, v); check("R5 w1c", v, 0);
    check("R5 irq pin", {31'b0, wdt_irq_o}, 0);
  endtask

  task automatic t_kick;
    logic [31:0] v;
    wr32(1, 32'd7);
    wr32(0, 32'd50);
    wr32(2, 32'h1234);
    rd32(0, v); check("R7 kick reload", v, 7);
    rd32(2, v); check("R7 trig stored", v, 32'h1234);
    ticks(3);
    wr32(2, 32'h1234);
    rd32(0, v); check("R7 same value no reload", v, 10);
  endtask

  task automatic t_keys;
    logic [31:0] v;
    wr32(0, 32'd0);
    wr32(3, 32'h0000_AA55); wr32(3, 32'h1); wr32(3, 32'h0000_55AA);
    rd32(3, v); check("R8 broken seq", v, 1);
    ticks(2);
    rd32(0, v); check("R8 still counting", v, 2);
    wr32(3, 32'h0000_AA55); wr32(3, 32'h0000_55AA);
    rd32(3, v); check("R8 stopped", v, 0);
    ticks(3);
    rd32(0, v); check("R8 frozen", v, 2);
    wr32(3, 32'h0000_BB66); wr32(3, 32'h0000_66BB);
    rd32(3, v); check("R8 restarted", v, 1);
    ticks(1);
    rd32(0, v); check("R8 counting again", v, 3);
  endtask

  task automatic t_sizes;
    logic [31:0] v; logic er;
    wr32(1, 32'h1111_2222);
    access(1'b1, 1, 4'b1100, 32'hAAAA_0000, 1'b0, v, er);
    check("R9 upper err", {31'b0, er}, 0);
    rd32(1, v); check("R9 upper half", v, 32'hAAAA_2222);
    access(1'b1, 1, 4'b0011, 32'h0000_5555, 1'b0, v, er);
    rd32(1, v); check("R9 lower half", v, 32'hAAAA_5555);
    access(1'b1, 1, 4'b0001, 32'h0000_0099, 1'b0, v, er);
    check("R10 byte err", {31'b0, er}, 1);
    rd32(1, v); check("R10 unchanged", v, 32'hAAAA_5555);
  endtask

  task automatic t_collide;
    logic [31:0] v; logic er;
    wr32(1, 32'h20);
    wr32(0, 32'hFFFF_FFFF);
    access(1'b1, 4, 4'hF, 32'h1, 1'b1, v, er);
    check("R11 set beats clear", {31'b0, wdt_irq_o}, 1);
    check("R11 rst high", {31'b0, wdt_rst_o}, 1);
    ticks(PL);
    wr32(4, 32'h1);
    wr32(0, 32'hFFFF_FFFF);
    access(1'b1, 2, 4'hF, 32'h5A5A, 1'b1, v, er);
    check("R12 rst high", {31'b0, wdt_rst_o}, 1);
    rd32(0, v); check("R12 count 0", v, 0);
    ticks(PL);
    rd32(0, v); check("R12 reload after pulse", v, 32'h20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_count();
    t_overflow();
    t_irq();
    t_kick();
    t_keys();
    t_sizes();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule